// File: doc/BRIEF.md
# DSP Rounding Unit

This block is the last stage of a fixed-point DSP datapath and carries out the rounding operation. The operand is 40 bits wide: a 32-bit value with 8 guard bits above it. The stage adds half of one unit of the retained part, which is the constant 0x8000. The sum wraps modulo 2^40. The stage then forces the low halfword to zero, so 24 significant bits remain in positions [39:16]. With guard bits unused, this is rounding a 32-bit value down to 16 bits.

The operation is unconditional. Every accepted input rewrites the whole status vector, and the condition select has no say in that. The status vector holds four flags:

- negative
- zero
- an overflow flag that this operation always clears
- strictly-positive

A fifth status bit is chosen by a 3-bit select code. It can show the carry out of the addition or one of the derived conditions. Result, status and valid are all registered and appear one clock after the input.

Top module: `dspr_round_unit`

## Requirements
- R1: When `in_valid` is high, the next clock loads `out_result` with ((`in_operand` + 0x8000) mod 2^40) with bits [15:0] cleared.
- R2: Whenever `out_valid` is high, bits [15:0] of `out_result` are zero.
- R3: `out_flags[0]` (negative) equals bit 39 of the registered result.
- R4: `out_flags[1]` (zero) is 1 exactly when all 40 bits of the registered result are zero.
- R5: `out_flags[2]` (overflow) is always 0. This includes a positive operand that wraps to a negative result.
- R6: `out_flags[3]` (greater-than) is 1 exactly when the result is non-negative and non-zero.
- R7: `out_valid` is `in_valid` delayed by one clock. Every valid input rewrites all flags, whatever the select code is.
- R8: While `in_valid` is low, `out_result` and `out_flags` keep their values.
- R9: A synchronous active-high `rst` clears `out_result`, `out_flags` and `out_valid` at the next clock.
- R10: `out_flags[4]` (selected bit) follows `in_dc_sel`:
  - 000 gives the carry out of bit 39 of the addition
  - 001 gives negative
  - 010 gives zero
  - 011 gives overflow
  - 100 gives signed greater-than
  - 101 gives signed greater-or-equal (not negative)
  - 110 and 111 give 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid |
| in_operand | input | 40 | Guard-extended source operand |
| in_dc_sel | input | 3 | Selects the source of status bit 4 |
| out_valid | output | 1 | Result valid, one clock after input |
| out_result | output | 40 | Rounded result |
| out_flags | output | 5 | {sel, gt, ovf, zero, neg} |

## Verification
The bench builds the unit with its default parameters: a 40-bit datapath with a 16-bit fraction. With these values the rounding constant is exactly 0x8000, and the carry boundary at 0xFF_FFFF_8000 can be reached with a single literal. The values around that boundary and around the extreme positive and negative operands are all driven directly. These include the positive-to-negative wrap and a negative input that rounds to zero with a carry. A long pseudo-random run then mixes idle cycles, every select code and one mid-run reset.

// File: rtl/dspr_pkg.sv
package dspr_pkg;

    typedef enum logic [2:0] {
        DC_CARRY = 3'b000,
        DC_NEG   = 3'b001,
        DC_ZERO  = 3'b010,
        DC_OVF   = 3'b011,
        DC_GT    = 3'b100,
        DC_GE    = 3'b101,
        DC_RSV6  = 3'b110,
        DC_RSV7  = 3'b111
    } dc_sel_e;

    typedef struct packed {
        logic dc;
        logic gt;
        logic ovf;
        logic zero;
        logic neg;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/dspr_round_core.sv
module dspr_round_core #(
    parameter int DATA_W = 40,
    parameter int FRAC_W = 16
) (
    input  logic [DATA_W-1:0] op_i,
    output logic [DATA_W-1:0] rounded_o,
    output logic              carry_o
);
    localparam int KEEP_W = DATA_W - FRAC_W;
    localparam logic [DATA_W-1:0] HALF =
        {{KEEP_W{1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{KEEP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [DATA_W:0] sum_w;

    always_comb begin
        sum_w     = {1'b0, op_i} + {1'b0, HALF};
        carry_o   = sum_w[DATA_W];
        rounded_o = sum_w[DATA_W-1:0] & KEEP_MASK;
    end
endmodule

// File: rtl/dspr_dc_mux.sv
module dspr_dc_mux
    import dspr_pkg::*;
(
    input  logic [2:0] sel_i,
    input  logic       carry_i,
    input  logic       neg_i,
    input  logic       zero_i,
    input  logic       ovf_i,
    input  logic       gt_i,
    output logic       dc_o
);
    always_comb begin
        case (dc_sel_e'(sel_i))
            DC_CARRY: dc_o = carry_i;
            DC_NEG:   dc_o = neg_i;
            DC_ZERO:  dc_o = zero_i;
            DC_OVF:   dc_o = ovf_i;
            DC_GT:    dc_o = gt_i;
            DC_GE:    dc_o = ~neg_i;
            default:  dc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dspr_flag_gen.sv
module dspr_flag_gen
    import dspr_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic [2:0]        sel_i,
    output flags_t            flags_o
);
    logic neg_w, zero_w, gt_w, dc_w;

    always_comb begin
        neg_w  = res_i[DATA_W-1];
        zero_w = (res_i == '0);
        gt_w   = ~neg_w & ~zero_w;
    end

    dspr_dc_mux u_dc_mux (
        .sel_i   (sel_i),
        .carry_i (carry_i),
        .neg_i   (neg_w),
        .zero_i  (zero_w),
        .ovf_i   (1'b0),
        .gt_i    (gt_w),
        .dc_o    (dc_w)
    );

    always_comb begin
        flags_o      = '0;
        flags_o.neg  = neg_w;
        flags_o.zero = zero_w;
        flags_o.ovf  = 1'b0;
        flags_o.gt   = gt_w;
        flags_o.dc   = dc_w;
    end
endmodule

// File: rtl/dspr_round_unit.sv
module dspr_round_unit
    import dspr_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [2:0]        in_dc_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [FLAG_W-1:0] out_flags
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        flags_t            flags;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] rounded_w;
    logic              carry_w;
    flags_t            flags_w;

    dspr_round_core #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W)
    ) u_core (
        .op_i      (in_operand),
        .rounded_o (rounded_w),
        .carry_o   (carry_w)
    );

    dspr_flag_gen #(
        .DATA_W (DATA_W)
    ) u_flags (
        .res_i   (rounded_w),
        .carry_i (carry_w),
        .sel_i   (in_dc_sel),
        .flags_o (flags_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = rounded_w;
            st_d.flags  = flags_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_flags  = st_q.flags;
endmodule

// File: rtl/dspr_round_checker.sv
module dspr_round_checker #(
    parameter int DATA_W = 40,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_operand,
    input logic [2:0]        in_dc_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [4:0]        out_flags
);
    localparam int KEEP_W = DATA_W - FRAC_W;
    localparam logic [DATA_W-1:0] HALF =
        {{KEEP_W{1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{KEEP_W{1'b1}}, {FRAC_W{1'b0}}};

    AST_ROUND_VALUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result == (($past(in_operand) + HALF) & KEEP_MASK)); // R1
    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result[FRAC_W-1:0] == '0); // R2
    AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_flags[0] == out_result[DATA_W-1]); // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_flags[1] == (out_result == '0)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_flags[2] == 1'b0); // R5
    AST_GT_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_flags[3] && (out_flags[0] || out_flags[1]))); // R6
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_flags)); // R8
    AST_DC_OVF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dc_sel == 3'b011) |=> out_flags[4] == 1'b0); // R10
    AST_DC_RSV: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dc_sel[2:1] == 2'b11) |=> out_flags[4] == 1'b0); // R10
    AST_DC_GE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dc_sel == 3'b101) |=> out_flags[4] == !out_flags[0]); // R10
endmodule

bind dspr_round_unit dspr_round_checker #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .in_dc_sel  (in_dc_sel),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags)
);

// File: tb/dspr_round_unit_tb.sv
module dspr_round_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [39:0] in_operand = '0;
    logic [2:0]  in_dc_sel = '0;
    logic        out_valid;
    logic [39:0] out_result;
    logic [4:0]  out_flags;

    int checks = 0;
    int fails  = 0;

    // expected state of the registered outputs
    logic        e_valid = 1'b0;
    logic [39:0] e_res   = '0;
    logic [4:0]  e_flags = '0;
    int          prev_kind = 0; // 0 reset, 1 valid, 2 idle

    always #4 clk = ~clk;

    dspr_round_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_dc_sel  (in_dc_sel),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        string t;
        t = (prev_kind == 0) ? "R9" : (prev_kind == 2) ? "R8" : "R1";
        chk(prev_kind == 0 ? "R9 valid" : "R7 valid", 64'(out_valid), 64'(e_valid));
        chk({t, " result"}, 64'(out_result), 64'(e_res));
        chk(prev_kind == 1 ? "R3 neg" : {t, " neg"}, 64'(out_flags[0]), 64'(e_flags[0]));
        chk(prev_kind == 1 ? "R4 zero" : {t, " zero"}, 64'(out_flags[1]), 64'(e_flags[1]));
        chk("R5 ovf", 64'(out_flags[2]), 64'(e_flags[2]));
        chk(prev_kind == 1 ? "R6 gt" : {t, " gt"}, 64'(out_flags[3]), 64'(e_flags[3]));
        chk(prev_kind == 1 ? "R10 dc" : {t, " dc"}, 64'(out_flags[4]), 64'(e_flags[4]));
        if (out_valid) chk("R2 low halfword", 64'(out_result[15:0]), 64'h0);
    endtask

    // behavioural reference: wide integer sum, then mask
    task automatic model(input logic [39:0] x, input logic [2:0] sel);
        logic [63:0] s;
        logic        c, n, z, g, d;
        s = 64'(x) + 64'h8000;
        c = s[40];
        e_res = s[39:0] & 40'hFF_FFFF_0000;
        n = e_res[39];
        z = (e_res == 40'h0);
        g = !n && !z;
        case (sel)
            3'd0: d = c;
            3'd1: d = n;
            3'd2: d = z;
            3'd3: d = 1'b0;
            3'd4: d = g;
            3'd5: d = !n;
            default: d = 1'b0;
        endcase
        e_flags = {d, g, 1'b0, z, n};
    endtask

    task automatic step(input logic r, input logic v, input logic [39:0] x, input logic [2:0] sel);
        @(negedge clk);
        compare();
        rst = r; in_valid = v; in_operand = x; in_dc_sel = sel;
        if (r) begin
            e_valid = 1'b0; e_res = '0; e_flags = '0; prev_kind = 0;
        end else begin
            e_valid = v;
            if (v) begin
                model(x, sel);
                prev_kind = 1;
            end else begin
                prev_kind = 2;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] lcg;
        repeat (2) @(posedge clk);
        step(1'b1, 1'b0, 40'h0, 3'd0);                 // reset held: R9
        step(1'b0, 1'b1, 40'h00_0000_0000, 3'd2);      // zero in, R4
        step(1'b0, 1'b1, 40'h00_0000_7FFF, 3'd4);      // rounds to zero
        step(1'b0, 1'b1, 40'h00_0000_8000, 3'd4);      // rounds up, R6
        step(1'b0, 1'b1, 40'h00_1234_ABCD, 3'd5);
        step(1'b0, 1'b1, 40'h7F_FFFF_7FFF, 3'd1);      // largest staying positive
        step(1'b0, 1'b1, 40'h7F_FFFF_FFFF, 3'd3);      // wraps negative, R5
        step(1'b0, 1'b1, 40'h7F_FFFF_FFFF, 3'd1);
        step(1'b0, 1'b1, 40'h80_0000_0000, 3'd5);      // most negative, R3
        step(1'b0, 1'b1, 40'hFF_FFFF_7FFF, 3'd0);      // no carry
        step(1'b0, 1'b1, 40'hFF_FFFF_8000, 3'd0);      // carry, rounds to zero, R10
        step(1'b0, 1'b1, 40'hFF_FFFF_FFFF, 3'd2);
        step(1'b0, 1'b0, 40'h12_3456_789A, 3'd4);      // ignored input, R8
        step(1'b0, 1'b0, 40'h00_0000_0000, 3'd1);
        for (int s = 0; s < 8; s++) begin
            step(1'b0, 1'b1, 40'hFF_FFFF_C000, 3'(s)); // every select, R10
            step(1'b0, 1'b1, 40'h00_0001_8000, 3'(s));
        end
        step(1'b1, 1'b1, 40'h00_4444_8000, 3'd0);      // reset beats valid, R9
        step(1'b0, 1'b1, 40'h00_4444_8000, 3'd4);      // R7
        lcg = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            step(i == 300, lcg[7:6] != 2'b00, lcg[63:24], lcg[12:10]);
        end
        step(1'b0, 1'b0, 40'h0, 3'd0);
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule